// File: doc/BRIEF.md
# Configurable Set/Reset Storage Cell

This block holds one bit. Parameters fix its kind and its forcing behaviour when it is built. It can be an edge-triggered flip-flop or a level-sensitive latch. It has a fixed power-up value, and it supports seven set/reset modes. Two control inputs can force the stored bit: `sr` and `rev`. A polarity parameter assigns the high-forcing role to one of them and the low-forcing role to the other. The mode then decides which of the two roles are honoured, and whether they act on the clock edge or at once.

Use it wherever a design needs a single stored bit with a defined force behaviour. A driving-low request ("reset" or "clear") always beats a driving-high request ("set" or "preset"). Both force requests beat the clock enable.

Top module: `sr_cell`

## Requirements
- R1: After power-up and before any force request or enabled capture, `q` equals the parameter `INIT_VAL`.
- R2: In flip-flop form, on a rising `clk` with `ce` high and no honoured force request, `q` takes the value of `d`.
- R3: In flip-flop form, on a rising `clk` with `ce` low and no honoured force request, `q` keeps its value.
- R4: With `SR_VAL` = 1, `sr` is the high-forcing input and `rev` the low-forcing input. With `SR_VAL` = 0 the roles are swapped. In a synchronous mode with the high path enabled, a high-forcing request alone sets `q` to 1 on the next rising `clk`.
- R5: In a synchronous mode with both paths enabled, high-forcing and low-forcing requests present at the same rising edge leave `q` at 0.
- R6: Synchronous force requests change `q` only at a rising `clk`, never between edges, and they take effect even when `ce` is low.
- R7: In an asynchronous mode, an honoured request changes `q` to its forced value at once, with no clock edge, in both flip-flop and latch form.
- R8: In the asynchronous mode with both paths enabled, simultaneous preset and clear requests give `q` = 0.
- R9: In latch form, `q` follows `d` while the gate (`clk`) is high and `ce` is high, and keeps its value while the gate is low.
- R10: A force input whose path the mode disables has no effect on `q`. In mode `SRM_NONE`, neither `sr` nor `rev` has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock in flip-flop form; active-high gate in latch form |
| ce | input | 1 | Clock enable, active high |
| d | input | 1 | Data input |
| sr | input | 1 | Force control; forces `SR_VAL` when its path is enabled |
| rev | input | 1 | Reverse force control; forces the complement of `SR_VAL` when its path is enabled |
| q | output | 1 | Stored bit |

## Verification
Synchronous results, whether a capture, a hold or a synchronous force, are due one rising edge after the inputs are applied. The bench therefore drives inputs just after a falling edge and compares at the next falling edge. Asynchronous results and the absence of change in synchronous modes are due within the same low clock phase, and are checked one time unit after the inputs change, with no edge in between. Latch transparency is due while the gate is high, so the latch output is also checked shortly after the rising edge, and again at the falling edge to confirm the hold.

// File: rtl/sr_cell_pkg.sv
package sr_cell_pkg;

  typedef enum logic [2:0] {
    SRM_NONE       = 3'd0,
    SRM_SYNC_SET   = 3'd1,
    SRM_SYNC_RST   = 3'd2,
    SRM_SYNC_BOTH  = 3'd3,
    SRM_ASYNC_PRE  = 3'd4,
    SRM_ASYNC_CLR  = 3'd5,
    SRM_ASYNC_BOTH = 3'd6
  } sr_mode_e;

  // Mode acts without waiting for a clock edge
  function automatic bit mode_is_async(sr_mode_e m);
    return (m == SRM_ASYNC_PRE) || (m == SRM_ASYNC_CLR) || (m == SRM_ASYNC_BOTH);
  endfunction

  // Mode honours the request that drives the bit to 1
  function automatic bit mode_has_high(sr_mode_e m);
    return (m == SRM_SYNC_SET) || (m == SRM_SYNC_BOTH) ||
           (m == SRM_ASYNC_PRE) || (m == SRM_ASYNC_BOTH);
  endfunction

  // Mode honours the request that drives the bit to 0
  function automatic bit mode_has_low(sr_mode_e m);
    return (m == SRM_SYNC_RST) || (m == SRM_SYNC_BOTH) ||
           (m == SRM_ASYNC_CLR) || (m == SRM_ASYNC_BOTH);
  endfunction

  // Priority: drive-low, then drive-high, then enabled load, else hold
  function automatic logic cell_resolve(logic lo, logic hi, logic load,
                                        logic din, logic held);
    if (lo)        return 1'b0;
    else if (hi)   return 1'b1;
    else if (load) return din;
    else           return held;
  endfunction

endpackage

// File: rtl/sr_cell_route.sv
module sr_cell_route
  import sr_cell_pkg::*;
#(
  parameter sr_mode_e MODE   = SRM_NONE,
  parameter bit       SR_VAL = 1'b0
) (
  input  logic sr,
  input  logic rev,
  output logic drv_high,
  output logic drv_low
);

  localparam bit HIGH_ON = mode_has_high(MODE);
  localparam bit LOW_ON  = mode_has_low(MODE);

  logic high_src;
  logic low_src;

  // sr forces SR_VAL, rev forces its complement
  assign high_src = SR_VAL ? sr  : rev;
  assign low_src  = SR_VAL ? rev : sr;

  assign drv_high = HIGH_ON && high_src;
  assign drv_low  = LOW_ON  && low_src;

endmodule

// File: rtl/sr_cell_ff.sv
module sr_cell_ff
  import sr_cell_pkg::*;
#(
  parameter bit ASYNC    = 1'b0,
  parameter bit INIT_VAL = 1'b0
) (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic drv_high,
  input  logic drv_low,
  output logic q
);

  logic q_reg = INIT_VAL;

  generate
    if (ASYNC) begin : g_async
      // Request edges update the register; the level override keeps q
      // correct while a lower-priority request is still held
      always_ff @(posedge clk or posedge drv_low or posedge drv_high) begin
        q_reg <= cell_resolve(drv_low, drv_high, ce, d, q_reg);
      end
      assign q = drv_low ? 1'b0 : (drv_high ? 1'b1 : q_reg);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q_reg <= cell_resolve(drv_low, drv_high, ce, d, q_reg);
      end
      assign q = q_reg;
    end
  endgenerate

endmodule

// File: rtl/sr_cell_latch.sv
module sr_cell_latch
  import sr_cell_pkg::*;
#(
  parameter bit ASYNC    = 1'b0,
  parameter bit INIT_VAL = 1'b0
) (
  input  logic gate,
  input  logic ce,
  input  logic d,
  input  logic drv_high,
  input  logic drv_low,
  output logic q
);

  logic q_lat = INIT_VAL;

  generate
    if (ASYNC) begin : g_async
      always_latch begin
        if (drv_low || drv_high || (gate && ce))
          q_lat = cell_resolve(drv_low, drv_high, 1'b1, d, q_lat);
      end
    end else begin : g_sync
      // Requests only act during the transparent phase
      always_latch begin
        if (gate && (drv_low || drv_high || ce))
          q_lat = cell_resolve(drv_low, drv_high, 1'b1, d, q_lat);
      end
    end
  endgenerate

  assign q = q_lat;

endmodule

// File: rtl/sr_cell.sv
module sr_cell
  import sr_cell_pkg::*;
#(
  parameter bit       IS_LATCH = 1'b0,
  parameter sr_mode_e MODE     = SRM_NONE,
  parameter bit       INIT_VAL = 1'b0,
  parameter bit       SR_VAL   = 1'b0
) (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic sr,
  input  logic rev,
  output logic q
);

  localparam bit ASYNC = mode_is_async(MODE);

  // Honoured force requests, brought out for the checker
  logic drv_high;
  logic drv_low;

  sr_cell_route #(.MODE(MODE), .SR_VAL(SR_VAL)) u_route (
    .sr       (sr),
    .rev      (rev),
    .drv_high (drv_high),
    .drv_low  (drv_low)
  );

  generate
    if (IS_LATCH) begin : g_latch
      sr_cell_latch #(.ASYNC(ASYNC), .INIT_VAL(INIT_VAL)) u_store (
        .gate     (clk),
        .ce       (ce),
        .d        (d),
        .drv_high (drv_high),
        .drv_low  (drv_low),
        .q        (q)
      );
    end else begin : g_ff
      sr_cell_ff #(.ASYNC(ASYNC), .INIT_VAL(INIT_VAL)) u_store (
        .clk      (clk),
        .ce       (ce),
        .d        (d),
        .drv_high (drv_high),
        .drv_low  (drv_low),
        .q        (q)
      );
    end
  endgenerate

endmodule

// File: rtl/sr_cell_chk.sv
module sr_cell_chk
  import sr_cell_pkg::*;
#(
  parameter bit       IS_LATCH = 1'b0,
  parameter sr_mode_e MODE     = SRM_NONE
) (
  input logic clk,
  input logic ce,
  input logic d,
  input logic q,
  input logic drv_high,
  input logic drv_low
);

  localparam bit SYNC_FF = !IS_LATCH && !mode_is_async(MODE);
  localparam bit ASYNC   = mode_is_async(MODE);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R5
  sync_low_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    (SYNC_FF && drv_low) |=> (q == 1'b0));

  // R4
  sync_high_chk: assert property (@(posedge clk) disable iff (!armed)
    (SYNC_FF && drv_high && !drv_low) |=> (q == 1'b1));

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!armed)
    (SYNC_FF && ce && !drv_high && !drv_low) |=> (q == $past(d)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (SYNC_FF && !ce && !drv_high && !drv_low) |=> $stable(q));

  always @(negedge clk) begin
    if (armed && ASYNC && drv_low) begin
      // R8
      async_clear_chk: assert (q == 1'b0);
    end
    if (armed && ASYNC && drv_high && !drv_low) begin
      // R7
      async_preset_chk: assert (q == 1'b1);
    end
  end

endmodule

bind sr_cell sr_cell_chk #(.IS_LATCH(IS_LATCH), .MODE(MODE)) u_chk (
  .clk      (clk),
  .ce       (ce),
  .d        (d),
  .q        (q),
  .drv_high (drv_high),
  .drv_low  (drv_low)
);

// File: tb/sr_cell_tb.sv
`timescale 1ns/1ps
module sr_cell_tb;
  import sr_cell_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic d = 1'b0, ce = 1'b0, sr = 1'b0, rev = 1'b0;
  logic qa, qb, qc, qd, qe;

  // A: sync flop, both paths, sr=set rev=reset
  sr_cell #(.IS_LATCH(1'b0), .MODE(SRM_SYNC_BOTH), .INIT_VAL(1'b0), .SR_VAL(1'b1)) u_dut (
    .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .q(qa));
  // B: async flop, both paths, sr=clear rev=preset
  sr_cell #(.IS_LATCH(1'b0), .MODE(SRM_ASYNC_BOTH), .INIT_VAL(1'b1), .SR_VAL(1'b0)) u_async (
    .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .q(qb));
  // C: latch, async clear only, rev=clear, sr disabled
  sr_cell #(.IS_LATCH(1'b1), .MODE(SRM_ASYNC_CLR), .INIT_VAL(1'b1), .SR_VAL(1'b1)) u_latch (
    .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .q(qc));
  // D: flop, no force paths
  sr_cell #(.IS_LATCH(1'b0), .MODE(SRM_NONE), .INIT_VAL(1'b1), .SR_VAL(1'b1)) u_none (
    .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .q(qd));
  // E: sync flop, set only, rev=set, sr disabled
  sr_cell #(.IS_LATCH(1'b0), .MODE(SRM_SYNC_SET), .INIT_VAL(1'b0), .SR_VAL(1'b0)) u_sset (
    .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .q(qe));

  int n_run = 0, n_fail = 0;
  bit reported = 1'b0;
  logic ma, mb, mc, md, me;

  task automatic check(input string req, input string who, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, who, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Expected value at an edge: zero beats one beats load
  function automatic logic edge_model(logic cur, logic to_one, logic to_zero,
                                      logic en, logic din);
    logic r;
    r = cur;
    if (en) r = din;
    if (to_one) r = 1'b1;
    if (to_zero) r = 1'b0;
    return r;
  endfunction

  task automatic step(input logic nd, input logic nce, input logic nsr, input logic nrev);
    logic qa_before;
    #1;
    qa_before = qa;
    d = nd; ce = nce; sr = nsr; rev = nrev;
    #1;
    // low phase: only asynchronous paths may act
    if (sr) mb = 1'b0; else if (rev) mb = 1'b1;
    if (rev) mc = 1'b0;
    check((sr && rev) ? "R8" : "R7", "async_ff", qb, mb);
    check("R7", "latch_lowphase", qc, mc);
    check("R6", "sync_no_edge", qa, qa_before);
    @(posedge clk);
    ma = edge_model(ma, sr, rev, ce, d);
    mb = edge_model(mb, rev, sr, ce, d);
    mc = edge_model(mc, 1'b0, rev, ce, d);
    md = edge_model(md, 1'b0, 1'b0, ce, d);
    me = edge_model(me, rev, 1'b0, ce, d);
    #1;
    check("R9", "latch_open", qc, mc);
    @(negedge clk);
    check(rev ? "R5" : (sr ? ((!ce) ? "R6" : "R4") : (ce ? "R2" : "R3")), "sync_both", qa, ma);
    check((sr || rev) ? "R7" : (ce ? "R2" : "R3"), "async_ff_edge", qb, mb);
    check("R9", "latch_hold", qc, mc);
    check("R10", "no_mode", qd, md);
    check((sr && !rev) ? "R10" : (rev ? "R4" : "R2"), "set_only", qe, me);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!reported) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ma = 1'b0; mb = 1'b1; mc = 1'b1; md = 1'b1; me = 1'b0;
    #1;
    check("R1", "init_a", qa, 1'b0);
    check("R1", "init_b", qb, 1'b1);
    check("R1", "init_c", qc, 1'b1);
    check("R1", "init_d", qd, 1'b1);
    check("R1", "init_e", qe, 1'b0);
    @(negedge clk);
    // directed corners
    step(1'b1, 1'b0, 1'b0, 1'b0);   // R3 hold with ce low
    step(1'b1, 1'b1, 1'b0, 1'b0);   // R2 capture 1
    step(1'b0, 1'b0, 1'b1, 1'b1);   // R5 / R8 both requests
    step(1'b0, 1'b0, 1'b1, 1'b0);   // R6 set overrides ce low, R10 sr ignored in E
    step(1'b1, 1'b1, 1'b0, 1'b1);   // R4 E set, A reset, C clear
    step(1'b0, 1'b0, 1'b0, 1'b1);   // preset held after clear
    step(1'b0, 1'b1, 1'b0, 1'b0);   // R2 capture 0
    step(1'b1, 1'b0, 1'b1, 1'b1);   // D ignores both (R10)
    step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom % 2), 1'($urandom % 2),
           1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0));
    end
    report();
  end

endmodule